// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This block does decimal arithmetic on a byte that holds two packed BCD digits (high digit in bits 7:4, low digit in bits 3:0). It offers three operations: add with extend, subtract with extend and negate with extend. Each operation folds the incoming extend bit into the decimal result. The decimal carry or borrow comes back out on both the extend and carry flags. A zero flag is cleared by any nonzero result and otherwise passed through.

A decimal string of any length is processed one byte at a time, least significant byte first. The caller feeds `x_out` back into `x_in` and `z_out` back into `z_in` between bytes. The final zero flag is then set only if every byte of the string came out zero. A strobe on `in_valid` latches the result and the flags into output registers, and `done` is high in the following cycle.

Top module: `bcd_byte_alu`

## Requirements
- R1: With `op` = 2'b00 (add), the result is the decimal value of `dst_bcd` + `src_bcd` + `x_in`, taken modulo 100. The carry is 1 exactly when that sum is 100 or more.
- R2: With `op` = 2'b01 (subtract), the result is `dst_bcd` − `src_bcd` − `x_in` in decimal. When that difference is negative, 100 is added to it and the borrow is 1; otherwise the borrow is 0.
- R3: With `op` = 2'b10 (negate), the result is 0 − `src_bcd` − `x_in` in decimal, with a borrow whenever that value is negative. This gives the ten's complement of the operand when `x_in` is 0 and the nine's complement when `x_in` is 1.
- R4: After each accepted operation, `x_out` and `c_out` both equal that operation's decimal carry (add) or borrow (subtract, negate).
- R5: After each accepted operation, `z_out` is 0 if the result byte is nonzero, and equals `z_in` if the result byte is zero.
- R6: `op` = 2'b11 is reserved. A strobe with it latches nothing and raises no `done`.
- R7: A strobe with a defined `op` updates the outputs at that clock edge. `done` is then high for the next cycle only, unless another strobe follows.
- R8: Without an accepted strobe, `res_bcd`, `x_out`, `c_out` and `z_out` hold their values whatever the other inputs do.
- R9: While `rst_n` is low at a clock edge, all outputs are cleared to 0.
- R10: Feeding `x_out` and `z_out` back as `x_in` and `z_in` from byte to byte yields the correct multi-byte decimal sum or difference. The final zero flag reports whether the whole string is zero.
- R11: A negate ignores `dst_bcd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: perform the operation this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 negate, 11 reserved |
| dst_bcd | input | 8 | Destination operand, two packed BCD digits |
| src_bcd | input | 8 | Source operand, two packed BCD digits |
| x_in | input | 1 | Incoming extend flag |
| z_in | input | 1 | Incoming zero flag |
| res_bcd | output | 8 | Registered decimal result |
| x_out | output | 1 | Registered extend flag |
| c_out | output | 1 | Registered carry/borrow flag |
| z_out | output | 1 | Registered zero flag |
| done | output | 1 | High the cycle after an accepted strobe |

## Verification
The vector set for each operation separates three kinds of case: no digit correction, correction in the low digit only, and a carry or borrow out of the high digit. This tells a missing nibble adjustment apart from a missing byte-level carry. Every operation is also tried with the extend bit both clear and set, which checks that X enters the low digit and, for negation, tells the ten's complement from the nine's. Zero results are tried with the incoming zero flag both set and clear, to show that the flag is passed through rather than forced to 1. Two-byte chains of an add and of subtracts, with a high byte that becomes zero while the whole value does not, show the carry and zero flags travelling between bytes.

// File: rtl/bcd_pkg.sv
// Package bcd_pkg: shared operation codes and digit width for the decimal unit.
// Assumes a packed BCD digit is four bits wide.
package bcd_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        BCD_ADD  = 2'b00,
        BCD_SUB  = 2'b01,
        BCD_NEG  = 2'b10,
        BCD_RSVD = 2'b11
    } bcd_op_e;
endpackage

// File: rtl/bcd_digit_add.sv
// Module bcd_digit_add: adds two BCD digits and a carry-in, with decimal correction.
// Assumes valid digits for a meaningful result; any other digit gives a fixed, repeatable output.
module bcd_digit_add
    import bcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    output logic [DIGIT_W-1:0] sum,
    output logic               cout
);
    logic [DIGIT_W:0] raw;

    // Binary sum, then add six when it passes nine.
    always_comb begin
        raw  = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
        cout = (raw > (DIGIT_W+1)'(9));
        sum  = cout ? (raw[DIGIT_W-1:0] + DIGIT_W'(6)) : raw[DIGIT_W-1:0];
    end
endmodule

// File: rtl/bcd_digit_sub.sv
// Module bcd_digit_sub: subtracts a BCD digit and a borrow-in from another digit.
// Assumes valid digits for a meaningful result; the correction subtracts six when the digit borrows.
module bcd_digit_sub
    import bcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               bin,
    output logic [DIGIT_W-1:0] diff,
    output logic               bout
);
    logic [DIGIT_W:0] raw;

    // Two's complement difference; its sign bit is the borrow.
    always_comb begin
        raw  = {1'b0, a} - {1'b0, b} - {{DIGIT_W{1'b0}}, bin};
        bout = raw[DIGIT_W];
        diff = bout ? (raw[DIGIT_W-1:0] - DIGIT_W'(6)) : raw[DIGIT_W-1:0];
    end
endmodule

// File: rtl/bcd_byte_core.sv
// Module bcd_byte_core: combinational decimal add, subtract and negate over DIGITS digits.
// Assumes the low digit sits in the least significant nibble; X enters the low digit.
module bcd_byte_core
    import bcd_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W     = DIGITS * DIGIT_W
) (
    input  bcd_op_e      op,
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src,
    input  logic         x_in,
    output logic [W-1:0] res,
    output logic         cy_out
);
    logic [DIGITS:0] add_c;
    logic [DIGITS:0] sub_b;
    logic [W-1:0]    add_r;
    logic [W-1:0]    sub_r;
    logic [W-1:0]    minuend;

    // Negate subtracts from zero, so the destination is masked off.
    always_comb minuend = (op == BCD_NEG) ? '0 : dst;

    assign add_c[0] = x_in;
    assign sub_b[0] = x_in;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bcd_digit_add u_add (
            .a   (dst[g*DIGIT_W +: DIGIT_W]),
            .b   (src[g*DIGIT_W +: DIGIT_W]),
            .cin (add_c[g]),
            .sum (add_r[g*DIGIT_W +: DIGIT_W]),
            .cout(add_c[g+1])
        );
        bcd_digit_sub u_sub (
            .a   (minuend[g*DIGIT_W +: DIGIT_W]),
            .b   (src[g*DIGIT_W +: DIGIT_W]),
            .bin (sub_b[g]),
            .diff(sub_r[g*DIGIT_W +: DIGIT_W]),
            .bout(sub_b[g+1])
        );
    end

    // Pick the chain the operation asks for.
    always_comb begin
        if (op == BCD_ADD) begin
            res    = add_r;
            cy_out = add_c[DIGITS];
        end else begin
            res    = sub_r;
            cy_out = sub_b[DIGITS];
        end
    end
endmodule

// File: rtl/bcd_byte_alu.sv
// Module bcd_byte_alu: registered packed-decimal unit with extend, carry and sticky zero flags.
// Assumes the caller chains bytes through x and z, least significant byte first;
// op code 3 is reserved and ignored.
module bcd_byte_alu
    import bcd_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W     = DIGITS * DIGIT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [W-1:0] dst_bcd,
    input  logic [W-1:0] src_bcd,
    input  logic         x_in,
    input  logic         z_in,
    output logic [W-1:0] res_bcd,
    output logic         x_out,
    output logic         c_out,
    output logic         z_out,
    output logic         done
);
    bcd_op_e      op_e;
    logic [W-1:0] core_res;
    logic         core_cy;
    logic         accept;
    logic         z_next;

    // Decode the operation and whether the strobe is taken.
    always_comb begin
        op_e   = bcd_op_e'(op);
        accept = in_valid && (op_e != BCD_RSVD);
        z_next = (core_res != '0) ? 1'b0 : z_in;
    end

    bcd_byte_core #(.DIGITS(DIGITS)) u_core (
        .op    (op_e),
        .dst   (dst_bcd),
        .src   (src_bcd),
        .x_in  (x_in),
        .res   (core_res),
        .cy_out(core_cy)
    );

    // Latch result and flags on an accepted strobe; done follows by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_bcd <= '0;
            x_out   <= 1'b0;
            c_out   <= 1'b0;
            z_out   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= accept;
            if (accept) begin
                res_bcd <= core_res;
                x_out   <= core_cy;
                c_out   <= core_cy;
                z_out   <= z_next;
            end
        end
    end
endmodule

// File: rtl/bcd_byte_alu_chk.sv
// Module bcd_byte_alu_chk: temporal checks on the port behaviour of bcd_byte_alu.
// Assumes synchronous active-low reset; attached through bind below.
module bcd_byte_alu_chk #(
    parameter int DIGITS = 2,
    localparam int W     = DIGITS * 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   op,
    input logic         z_in,
    input logic [W-1:0] res_bcd,
    input logic         x_out,
    input logic         c_out,
    input logic         z_out,
    input logic         done
);
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 2'b11) |=> done); // R7
    AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && op != 2'b11)); // R7
    AST_RESERVED_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=> !done); // R6
    AST_Z_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_bcd != '0) |-> !z_out); // R5
    AST_Z_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_bcd == '0) |-> (z_out == $past(z_in))); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(res_bcd) && $stable(x_out) && $stable(c_out) && $stable(z_out))); // R8
endmodule

bind bcd_byte_alu bcd_byte_alu_chk #(.DIGITS(DIGITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .op      (op),
    .z_in    (z_in),
    .res_bcd (res_bcd),
    .x_out   (x_out),
    .c_out   (c_out),
    .z_out   (z_out),
    .done    (done)
);

// File: tb/bcd_byte_alu_test.sv
`timescale 1ns/1ps
module bcd_byte_alu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] op = 2'b00;
    logic [7:0] dst_bcd = 8'h00;
    logic [7:0] src_bcd = 8'h00;
    logic       x_in = 1'b0;
    logic       z_in = 1'b0;
    logic [7:0] res_bcd;
    logic       x_out, c_out, z_out, done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bcd_byte_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .dst_bcd(dst_bcd), .src_bcd(src_bcd), .x_in(x_in), .z_in(z_in),
        .res_bcd(res_bcd), .x_out(x_out), .c_out(c_out), .z_out(z_out), .done(done)
    );

    // {op, dst, src, x, z, expected result, expected carry, expected zero}
    localparam int NV = 15;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 8'h12, 8'h34, 1'b0, 1'b1, 8'h46, 1'b0, 1'b0},
        {2'd0, 8'h45, 8'h55, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},
        {2'd0, 8'h99, 8'h99, 1'b1, 1'b0, 8'h99, 1'b1, 1'b0},
        {2'd0, 8'h09, 8'h01, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0},
        {2'd0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
        {2'd1, 8'h46, 8'h12, 1'b0, 1'b1, 8'h34, 1'b0, 1'b0},
        {2'd1, 8'h10, 8'h01, 1'b0, 1'b0, 8'h09, 1'b0, 1'b0},
        {2'd1, 8'h00, 8'h01, 1'b0, 1'b1, 8'h99, 1'b1, 1'b0},
        {2'd1, 8'h50, 8'h49, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1},
        {2'd1, 8'h00, 8'h99, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},
        {2'd2, 8'h77, 8'h25, 1'b0, 1'b1, 8'h75, 1'b1, 1'b0},
        {2'd2, 8'h33, 8'h25, 1'b1, 1'b1, 8'h74, 1'b1, 1'b0},
        {2'd2, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
        {2'd2, 8'h00, 8'h00, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0},
        {2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    // One strobe; returns with outputs settled after the capturing edge.
    task automatic run_op(input logic [1:0] o, input logic [7:0] d, input logic [7:0] s,
                          input logic x, input logic z);
        @(negedge clk);
        op = o; dst_bcd = d; src_bcd = s; x_in = x; z_in = z; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 res", res_bcd, 0);
        chk("R9 flags", {x_out, c_out, z_out, done}, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R11: vector table
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][29:28], VEC[i][27:20], VEC[i][19:12], VEC[i][11], VEC[i][10]);
            chk("R1/R2/R3 result", res_bcd, VEC[i][9:2]);
            chk("R4 x", x_out, VEC[i][1]);
            chk("R4 c", c_out, VEC[i][1]);
            chk("R5 z", z_out, VEC[i][0]);
            chk("R7 done", done, 1);
        end

        // R7: done lasts one cycle
        @(negedge clk);
        chk("R7 done drop", done, 0);

        // R8: idle inputs change, outputs hold (last result 00, c0, z0)
        op = 2'd1; dst_bcd = 8'h55; src_bcd = 8'h11; x_in = 1'b1; z_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 hold res", res_bcd, 8'h00);
        chk("R8 hold flags", {x_out, c_out, z_out}, 0);

        // R6: reserved op latches nothing
        run_op(2'd3, 8'h12, 8'h34, 1'b1, 1'b1);
        chk("R6 no done", done, 0);
        chk("R6 res kept", res_bcd, 8'h00);
        chk("R6 flags kept", {x_out, c_out, z_out}, 0);

        // R11: negate ignores destination
        run_op(2'd2, 8'h99, 8'h01, 1'b0, 1'b1);
        chk("R11 neg dst ignored", res_bcd, 8'h99);

        // R10: 1999 + 0001 = 2000, nonzero
        run_op(2'd0, 8'h99, 8'h01, 1'b0, 1'b1);
        chk("R10 add byte0", res_bcd, 8'h00);
        run_op(2'd0, 8'h19, 8'h00, x_out, z_out);
        chk("R10 add byte1", res_bcd, 8'h20);
        chk("R10 add carry", c_out, 0);
        chk("R10 add zero", z_out, 0);

        // R10: 0100 - 0001 = 0099, high byte zero but string nonzero
        run_op(2'd1, 8'h00, 8'h01, 1'b0, 1'b1);
        chk("R10 sub byte0", res_bcd, 8'h99);
        run_op(2'd1, 8'h01, 8'h00, x_out, z_out);
        chk("R10 sub byte1", res_bcd, 8'h00);
        chk("R10 sub zero sticky", z_out, 0);

        // R10: 0100 - 0100 = 0000, zero for the whole string
        run_op(2'd1, 8'h00, 8'h00, 1'b0, 1'b1);
        run_op(2'd1, 8'h01, 8'h01, x_out, z_out);
        chk("R10 zero string", z_out, 1);
        chk("R10 zero borrow", x_out, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule